// File: doc/BRIEF.md
# Register-init command table executor

The block runs a register-programming script that is stored as packed 32-bit words in a local table memory. A start pulse supplies the table base offset and the table length in dwords. The block then fetches words one after another and decodes each command header. It carries out each command on a simple register bus that has a request/ready handshake.

Five command kinds are supported: a plain register write, an indirect write into a selectable index space, a read-modify-write under a mask, a masked poll with a bounded retry count, and a terminator. Every run ends with a one-cycle done pulse and a mailbox-style response code. The code tells the caller one of five things: the script finished, it ran out of table, a poll gave up, a command did not fit in the table, or a header carried an unknown command type.

A run is launched once the table has been loaded. The caller waits for the done pulse and reads the code. The block ignores new start requests while a run is in progress.

Top module: `cmd_table_exec`

## Requirements
- R1: After reset, busy_o, done_o, reg_req_o and mem_rd_o are 0 and resp_o is 0.
- R2: Bits 31:28 of a header select the command type: 0 is a direct write, 2 a poll, 3 a read-modify-write, 8 an indirect write and 0xF the end. For a direct command, bits 27:0 go out on reg_addr_o, with reg_ind_o=0 and reg_space_o=0. Table dword i is read from memory address (offset+i) mod 2^TBL_AW.
- R3: A direct write takes two dwords, the header and then the value. The value is written to the addressed register.
- R4: A read-modify-write takes three dwords in the order header, data, mask. It reads the register and then writes back (old & ~mask) | (data & mask).
- R5: An indirect write takes two dwords, the header and then the value. reg_addr_o carries header bits 19:0, zero-extended. reg_space_o carries header bits 27:20. reg_ind_o is 1.
- R6: A poll takes three dwords in the order header, mask, expected value. It reads the register again and again until (value & mask) equals the expected value, and then moves on to the next command.
- R7: A poll fails when poll_limit_i+1 reads have all mismatched. The run then stops with response 3, and no later command is executed.
- R8: An end command stops the run with response 1. resp_o is valid from the cycle in which done_o pulses high for one cycle, and it holds until the next run completes.
- R9: An unknown command type stops the run with response 5. Commands before it take effect and commands after it do not.
- R10: If the next header would lie at or beyond offset+size, the run stops with response 2. This includes size 0.
- R11: If a command's payload would extend past offset+size, the run stops with response 4 and the command is not executed. The block never reads a table word at or beyond offset+size.
- R12: start_i is accepted only while busy_o is 0. A start while busy has no effect on the run in progress.
- R13: A register request holds its address, direction and write data stable until a cycle with reg_ready_i=1 completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| tbl_off_i | input | TBL_AW | Table base offset in dwords |
| tbl_size_i | input | TBL_AW+1 | Table length in dwords |
| poll_limit_i | input | POLL_W | Number of extra poll reads allowed |
| mem_rd_o | output | 1 | Table memory read strobe |
| mem_addr_o | output | TBL_AW | Table memory dword address |
| mem_data_i | input | 32 | Table read data, one cycle after the strobe |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 for a write, 0 for a read |
| reg_ind_o | output | 1 | Access goes to an indirect index space |
| reg_space_o | output | 8 | Index space select for indirect accesses |
| reg_addr_o | output | 28 | Register offset |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data, valid with ready |
| reg_ready_i | input | 1 | Completes the current request |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| resp_o | output | 3 | Response code of the last run |

## Verification
Some properties are checked by the assertions on every cycle. Register requests must stay stable until ready arrives. The block must never have a table read and a register access active at once. It must stay quiet on both buses while idle. Direct accesses must leave the space select at zero, table reads must stay inside the window latched at start, and every done pulse must carry a legal code. The remaining behaviour can only be shown by the bench's scenarios: the merge value of a read-modify-write, the number of reads a poll makes before it succeeds or gives up, and the stopping point and response code of each early-termination case. The bench also covers address wrap in the table memory and a start request that arrives in the middle of a run.

// File: rtl/cte_pkg.sv
package cte_pkg;
  localparam logic [3:0] OP_WR   = 4'h0;
  localparam logic [3:0] OP_POLL = 4'h2;
  localparam logic [3:0] OP_RMW  = 4'h3;
  localparam logic [3:0] OP_IWR  = 4'h8;
  localparam logic [3:0] OP_END  = 4'hF;

  localparam logic [2:0] RESP_NONE  = 3'd0;
  localparam logic [2:0] RESP_OK    = 3'd1;
  localparam logic [2:0] RESP_INCMP = 3'd2;
  localparam logic [2:0] RESP_FAIL  = 3'd3;
  localparam logic [2:0] RESP_SMALL = 3'd4;
  localparam logic [2:0] RESP_UNK   = 3'd5;

  typedef struct packed {
    logic       known;
    logic       is_end;
    logic       is_poll;
    logic       is_rmw;
    logic       is_ind;
    logic [1:0] len;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR_RD, ST_HDR_WT, ST_PL_RD, ST_PL_WT, ST_BUS_RD, ST_BUS_WR, ST_DONE
  } st_e;
endpackage

// File: rtl/cte_decode.sv
module cte_decode
  import cte_pkg::*;
(
  input  logic [3:0] op_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (op_i)
      OP_WR:   begin dec_o.known = 1'b1; dec_o.len = 2'd2; end
      OP_IWR:  begin dec_o.known = 1'b1; dec_o.len = 2'd2; dec_o.is_ind = 1'b1; end
      OP_RMW:  begin dec_o.known = 1'b1; dec_o.len = 2'd3; dec_o.is_rmw = 1'b1; end
      OP_POLL: begin dec_o.known = 1'b1; dec_o.len = 2'd3; dec_o.is_poll = 1'b1; end
      OP_END:  begin dec_o.known = 1'b1; dec_o.len = 2'd1; dec_o.is_end = 1'b1; end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/cte_retry_ctr.sv
module cte_retry_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         spent_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = (cnt_q == limit_i);
endmodule

// File: rtl/cte_merge.sv
module cte_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] new_o
);
  assign new_o = (old_i & ~mask_i) | (data_i & mask_i);
endmodule

// File: rtl/cmd_table_exec.sv
module cmd_table_exec
  import cte_pkg::*;
#(
  parameter int TBL_AW = 8,
  parameter int POLL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TBL_AW-1:0] tbl_off_i,
  input  logic [TBL_AW:0]   tbl_size_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  output logic              mem_rd_o,
  output logic [TBL_AW-1:0] mem_addr_o,
  input  logic [31:0]       mem_data_i,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic              reg_ind_o,
  output logic [7:0]        reg_space_o,
  output logic [27:0]       reg_addr_o,
  output logic [31:0]       reg_wdata_o,
  input  logic [31:0]       reg_rdata_i,
  input  logic              reg_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        resp_o
);
  localparam int SW = TBL_AW + 1;

  st_e               st_q;
  logic [TBL_AW-1:0] base_q;
  logic [SW-1:0]     size_q, idx_q;
  logic [POLL_W-1:0] lim_q;
  logic [27:0]       hdr_q;
  logic              ind_q, rmw_q, poll_q, three_q, pl_sel_q;
  logic [31:0]       w1_q, w2_q, wdata_q;
  logic [2:0]        resp_q;

  dec_t              dec;
  logic [SW:0]       need_end;
  logic [31:0]       merged;
  logic              rt_clr, rt_inc, rt_spent;
  logic              xfer, poll_hit;

  cte_decode u_dec (.op_i(mem_data_i[31:28]), .dec_o(dec));

  cte_merge #(.DW(32)) u_merge (
    .old_i(reg_rdata_i), .data_i(w1_q), .mask_i(w2_q), .new_o(merged)
  );

  cte_retry_ctr #(.W(POLL_W)) u_rt (
    .clk_i, .rst_ni, .clr_i(rt_clr), .inc_i(rt_inc), .limit_i(lim_q), .spent_o(rt_spent)
  );

  assign need_end = {1'b0, idx_q} + {{(SW-1){1'b0}}, dec.len};
  assign xfer     = reg_req_o && reg_ready_i;
  assign poll_hit = ((reg_rdata_i & w1_q) == w2_q);
  assign rt_clr   = (st_q == ST_PL_WT);
  assign rt_inc   = (st_q == ST_BUS_RD) && xfer && poll_q && !poll_hit && !rt_spent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      size_q   <= '0;
      idx_q    <= '0;
      lim_q    <= '0;
      hdr_q    <= '0;
      ind_q    <= 1'b0;
      rmw_q    <= 1'b0;
      poll_q   <= 1'b0;
      three_q  <= 1'b0;
      pl_sel_q <= 1'b0;
      w1_q     <= '0;
      w2_q     <= '0;
      wdata_q  <= '0;
      resp_q   <= RESP_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q <= tbl_off_i;
            size_q <= tbl_size_i;
            lim_q  <= poll_limit_i;
            idx_q  <= '0;
            st_q   <= ST_HDR_RD;
          end
        end
        ST_HDR_RD: begin
          if (idx_q == size_q) begin
            resp_q <= RESP_INCMP;
            st_q   <= ST_DONE;
          end else begin
            st_q <= ST_HDR_WT;
          end
        end
        ST_HDR_WT: begin
          hdr_q    <= mem_data_i[27:0];
          ind_q    <= dec.is_ind;
          rmw_q    <= dec.is_rmw;
          poll_q   <= dec.is_poll;
          three_q  <= (dec.len == 2'd3);
          pl_sel_q <= 1'b0;
          idx_q    <= idx_q + 1'b1;
          if (!dec.known) begin
            resp_q <= RESP_UNK;
            st_q   <= ST_DONE;
          end else if (dec.is_end) begin
            resp_q <= RESP_OK;
            st_q   <= ST_DONE;
          end else if (need_end > {1'b0, size_q}) begin
            resp_q <= RESP_SMALL;
            st_q   <= ST_DONE;
          end else begin
            st_q <= ST_PL_RD;
          end
        end
        ST_PL_RD: st_q <= ST_PL_WT;
        ST_PL_WT: begin
          idx_q <= idx_q + 1'b1;
          if (!pl_sel_q) w1_q <= mem_data_i;
          else           w2_q <= mem_data_i;
          if (three_q && !pl_sel_q) begin
            pl_sel_q <= 1'b1;
            st_q     <= ST_PL_RD;
          end else if (three_q) begin
            st_q <= ST_BUS_RD;
          end else begin
            wdata_q <= mem_data_i;
            st_q    <= ST_BUS_WR;
          end
        end
        ST_BUS_RD: begin
          if (xfer) begin
            if (rmw_q) begin
              wdata_q <= merged;
              st_q    <= ST_BUS_WR;
            end else if (poll_hit) begin
              st_q <= ST_HDR_RD;
            end else if (rt_spent) begin
              resp_q <= RESP_FAIL;
              st_q   <= ST_DONE;
            end
          end
        end
        ST_BUS_WR: if (xfer) st_q <= ST_HDR_RD;
        ST_DONE:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_o    = (st_q == ST_PL_RD) || ((st_q == ST_HDR_RD) && (idx_q != size_q));
  assign mem_addr_o  = base_q + idx_q[TBL_AW-1:0];
  assign reg_req_o   = (st_q == ST_BUS_RD) || (st_q == ST_BUS_WR);
  assign reg_we_o    = (st_q == ST_BUS_WR);
  assign reg_ind_o   = ind_q;
  assign reg_space_o = ind_q ? hdr_q[27:20] : 8'h00;
  assign reg_addr_o  = ind_q ? {8'h00, hdr_q[19:0]} : hdr_q;
  assign reg_wdata_o = wdata_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign resp_o      = resp_q;
endmodule

// File: rtl/cte_checker.sv
module cte_checker #(
  parameter int TBL_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [TBL_AW-1:0] tbl_off_i,
  input logic [TBL_AW:0]   tbl_size_i,
  input logic              mem_rd_o,
  input logic [TBL_AW-1:0] mem_addr_o,
  input logic              reg_req_o,
  input logic              reg_we_o,
  input logic              reg_ind_o,
  input logic [7:0]        reg_space_o,
  input logic [27:0]       reg_addr_o,
  input logic [31:0]       reg_wdata_o,
  input logic              reg_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [2:0]        resp_o
);
  logic [TBL_AW-1:0] c_base;
  logic [TBL_AW:0]   c_size;
  logic [TBL_AW-1:0] c_rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_base <= '0;
      c_size <= '0;
    end else if (start_i && !busy_o) begin
      c_base <= tbl_off_i;
      c_size <= tbl_size_i;
    end
  end

  assign c_rel = mem_addr_o - c_base;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ready_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o)
      && $stable(reg_wdata_o) && $stable(reg_ind_o)); // R13
  AST_BUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && reg_req_o)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !reg_req_o && !mem_rd_o && !done_o); // R12
  AST_DIRECT_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ind_o |-> reg_space_o == 8'h00); // R2
  AST_TBL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> {1'b0, c_rel} < c_size); // R11
  AST_DONE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> resp_o >= 3'd1 && resp_o <= 3'd5 && !done_o); // R8
endmodule

bind cmd_table_exec cte_checker #(.TBL_AW(TBL_AW)) u_cte_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tbl_off_i(tbl_off_i),
  .tbl_size_i(tbl_size_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
  .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_ind_o(reg_ind_o),
  .reg_space_o(reg_space_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
  .reg_ready_i(reg_ready_i), .busy_o(busy_o), .done_o(done_o), .resp_o(resp_o)
);

// File: tb/tb_cmd_table_exec.sv
module tb_cmd_table_exec;
  localparam int AW = 8;
  localparam int PW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] tbl_off_i = '0;
  logic [AW:0]   tbl_size_i = '0;
  logic [PW-1:0] poll_limit_i = '0;
  logic          mem_rd_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_data_i;
  logic          reg_req_o, reg_we_o, reg_ind_o;
  logic [7:0]    reg_space_o;
  logic [27:0]   reg_addr_o;
  logic [31:0]   reg_wdata_o, reg_rdata_i;
  logic          reg_ready_i = 1'b0;
  logic          busy_o, done_o;
  logic [2:0]    resp_o;

  always #2 clk_i = ~clk_i;

  cmd_table_exec #(.TBL_AW(AW), .POLL_W(PW)) dut (.*);

  logic [31:0] tmem [256];
  logic [31:0] mem_q = '0;
  always @(posedge clk_i) if (mem_rd_o) mem_q <= tmem[mem_addr_o];
  assign mem_data_i = mem_q;

  logic [31:0] rf [16];
  logic [31:0] poll_val;
  int          lat, wait_c, rd_cnt;
  logic [7:0]  ind_sp;
  logic [27:0] ind_ad, last_wr_ad;
  logic [31:0] ind_d;

  assign reg_rdata_i = (reg_addr_o[3:0] == 4'hF) ? poll_val : rf[reg_addr_o[3:0]];

  always @(posedge clk_i) begin
    if (reg_req_o && reg_ready_i) begin
      reg_ready_i <= 1'b0;
      wait_c <= 0;
      if (reg_we_o) begin
        if (reg_ind_o) begin
          ind_sp <= reg_space_o; ind_ad <= reg_addr_o; ind_d <= reg_wdata_o;
        end else begin
          rf[reg_addr_o[3:0]] <= reg_wdata_o;
          last_wr_ad <= reg_addr_o;
        end
      end else begin
        rd_cnt <= rd_cnt + 1;
        if (reg_addr_o[3:0] == 4'hF) poll_val <= poll_val + 1;
      end
    end else if (reg_req_o && wait_c >= lat) reg_ready_i <= 1'b1;
    else if (reg_req_o) wait_c <= wait_c + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [2:0] got;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hd(logic [3:0] op, logic [27:0] off);
    return {op, off};
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 16; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) tmem[i] = 32'hF000_0000;
    poll_val = '0; rd_cnt = 0; lat = 0; wait_c = 0;
    ind_sp = '0; ind_ad = '0; ind_d = '0; last_wr_ad = '0;
  endtask

  task automatic run(logic [AW-1:0] off, logic [AW:0] sz, logic [PW-1:0] lim);
    @(negedge clk_i);
    tbl_off_i = off; tbl_size_i = sz; poll_limit_i = lim; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      if (done_o) break;
      @(negedge clk_i);
    end
    got = resp_o;
    @(negedge clk_i);
    got = resp_o;
  endtask

  task automatic t_reset();
    check("R1 busy", {31'b0, busy_o}, 0);
    check("R1 done", {31'b0, done_o}, 0);
    check("R1 req", {31'b0, reg_req_o}, 0);
    check("R1 memrd", {31'b0, mem_rd_o}, 0);
    check("R1 resp", {29'b0, resp_o}, 0);
  endtask

  task automatic t_write();
    clear_model();
    tmem[0] = hd(4'h0, 28'hABCDE01); tmem[1] = 32'hDEADBEEF;
    tmem[2] = hd(4'h0, 28'h8765432); tmem[3] = 32'h00C0FFEE;
    tmem[4] = hd(4'hF, 28'h0);
    lat = 1;
    run(0, 5, 0);
    check("R3 rf1", rf[1], 32'hDEADBEEF);
    check("R3 rf2", rf[2], 32'h00C0FFEE);
    check("R2 addr", {4'h0, last_wr_ad}, 32'h08765432);
    check("R8 resp", {29'b0, got}, 1);
  endtask

  task automatic t_rmw();
    clear_model();
    rf[3] = 32'hFFFF0000;
    tmem[0] = hd(4'h3, 28'h3); tmem[1] = 32'h12345678; tmem[2] = 32'h00FF00FF;
    tmem[3] = hd(4'hF, 28'h0);
    run(0, 4, 0);
    check("R4 rf3", rf[3], 32'hFF340078);
    check("R4 resp", {29'b0, got}, 1);
  endtask

  task automatic t_ind();
    clear_model();
    tmem[0] = {4'h8, 8'hA5, 20'h12345}; tmem[1] = 32'hCAFEF00D;
    tmem[2] = hd(4'hF, 28'h0);
    run(0, 3, 0);
    check("R5 space", {24'b0, ind_sp}, 32'hA5);
    check("R5 addr", {4'h0, ind_ad}, 32'h00012345);
    check("R5 data", ind_d, 32'hCAFEF00D);
    check("R5 direct untouched", rf[5], 0);
  endtask

  task automatic t_poll_ok();
    clear_model();
    lat = 2;
    tmem[0] = hd(4'h2, 28'hF); tmem[1] = 32'hF; tmem[2] = 32'h3;
    tmem[3] = hd(4'h0, 28'h4); tmem[4] = 32'h44;
    tmem[5] = hd(4'hF, 28'h0);
    run(0, 6, 5);
    check("R6 reads", poll_val, 4);
    check("R6 next cmd", rf[4], 32'h44);
    check("R6 resp", {29'b0, got}, 1);
  endtask

  task automatic t_poll_fail();
    clear_model();
    tmem[0] = hd(4'h2, 28'hF); tmem[1] = 32'hF; tmem[2] = 32'h9;
    tmem[3] = hd(4'h0, 28'h6); tmem[4] = 32'h66;
    tmem[5] = hd(4'hF, 28'h0);
    run(0, 6, 2);
    check("R7 reads", poll_val, 3);
    check("R7 resp", {29'b0, got}, 3);
    check("R7 no later cmd", rf[6], 0);
  endtask

  task automatic t_unknown();
    clear_model();
    tmem[0] = hd(4'h0, 28'h7); tmem[1] = 32'h77;
    tmem[2] = hd(4'h1, 28'h8);
    tmem[3] = hd(4'h0, 28'h8); tmem[4] = 32'h88;
    tmem[5] = hd(4'hF, 28'h0);
    run(0, 6, 0);
    check("R9 resp", {29'b0, got}, 5);
    check("R9 before", rf[7], 32'h77);
    check("R9 after", rf[8], 0);
  endtask

  task automatic t_noend();
    clear_model();
    tmem[0] = hd(4'h0, 28'h9); tmem[1] = 32'h99;
    run(0, 2, 0);
    check("R10 resp", {29'b0, got}, 2);
    check("R10 rf9", rf[9], 32'h99);
    run(0, 0, 0);
    check("R10 size0 resp", {29'b0, got}, 2);
  endtask

  task automatic t_small();
    clear_model();
    rf[11] = 32'h5A5A5A5A;
    tmem[0] = hd(4'h0, 28'hA); tmem[1] = 32'hAA;
    tmem[2] = hd(4'h3, 28'hB); tmem[3] = 32'h0; tmem[4] = 32'hFFFFFFFF;
    tmem[5] = hd(4'hF, 28'h0);
    run(0, 4, 0);
    check("R11 resp", {29'b0, got}, 4);
    check("R11 before", rf[10], 32'hAA);
    check("R11 not executed", rf[11], 32'h5A5A5A5A);
  endtask

  task automatic t_wrap();
    clear_model();
    tmem[8'hFD] = hd(4'h0, 28'hC); tmem[8'hFE] = 32'h0C0C0C0C;
    tmem[8'hFF] = hd(4'h0, 28'hD); tmem[8'h00] = 32'h0D0D0D0D;
    tmem[8'h01] = hd(4'hF, 28'h0);
    run(8'hFD, 5, 0);
    check("R2 wrap rf12", rf[12], 32'h0C0C0C0C);
    check("R2 wrap rf13", rf[13], 32'h0D0D0D0D);
    check("R2 wrap resp", {29'b0, got}, 1);
  endtask

  task automatic t_busy_start();
    clear_model();
    lat = 3;
    tmem[0] = hd(4'h2, 28'hF); tmem[1] = 32'hF; tmem[2] = 32'h2;
    tmem[3] = hd(4'hF, 28'h0);
    tmem[16] = hd(4'h0, 28'hE); tmem[17] = 32'hEEEE;
    tmem[18] = hd(4'hF, 28'h0);
    @(negedge clk_i);
    tbl_off_i = 0; tbl_size_i = 4; poll_limit_i = 8; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (8) @(negedge clk_i);
    check("R12 busy mid-run", {31'b0, busy_o}, 1);
    tbl_off_i = 16; tbl_size_i = 3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      if (done_o) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    check("R12 resp", {29'b0, resp_o}, 1);
    check("R12 ignored start", rf[14], 0);
    check("R12 poll reads", poll_val, 3);
    check("R12 idle", {31'b0, busy_o}, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_write();
    t_rmw();
    t_ind();
    t_poll_ok();
    t_poll_fail();
    t_unknown();
    t_noend();
    t_small();
    t_wrap();
    t_busy_start();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end
endmodule